// File: doc/BRIEF.md
# Supply Rail Power-Up and Power-Down Sequencer

This block is a synchronous state machine that switches the supply rails of a target FPGA on and off in a fixed order. Its inputs are digital flags from voltage comparators and status pins. One flag says the sequencer's own supply is good. Another says the core rail has passed its minimum voltage. Further flags give per-rail good status, configuration complete, a shutdown request, the aux rail falling below its low threshold, and a restart request. All of these inputs are asynchronous, and each one passes through a two-flop synchronizer.

At power-up the block enables the core, low-voltage I/O and high-voltage I/O regulators together. It enables the aux regulator only once the core comparator reports that the core rail is above its minimum. When every rail-good flag has stayed high for a set number of cycles, the block raises power-good, which allows configuration to start. It then waits a bounded time for configuration to complete.

Shutdown can be caused by a missed configuration deadline, a rail fault or an external request. In every case the aux rail is removed first. The block waits until the aux rail reads below its low threshold, then removes the remaining rails. It then stays off until a restart request arrives. A sticky code records why the shutdown happened.

Top module: `rail_seq_ctrl`

## Requirements
- R1: After reset, all four regulator enables are low, power-good is low, the state code is 0 and the fault code is 0.
- R2: No regulator enable asserts while the synchronized own-supply-good input is low. The state stays at code 0 (wait for supply).
- R3: When own-supply-good is seen high, the core, low-voltage I/O and high-voltage I/O enables assert in the same cycle and the aux enable stays low. The state code becomes 1.
- R4: The aux enable asserts only after the core-above-minimum input is seen high. The state code becomes 2.
- R5: Power-good asserts only after every rail-good bit has been continuously high for SETTLE_CYC cycles. Any dropped bit restarts that count. The state code becomes 3.
- R6: If configuration-done is not seen within (CLK_HZ/1000)*DONE_MS cycles of power-good asserting, shutdown starts with fault code 1.
- R7: If configuration-done arrives in time, the state code becomes 4 (running) and power-good stays high.
- R8: In state 3 or 4, a low rail-good bit starts shutdown with fault code 2. Otherwise, a shutdown request starts shutdown with fault code 3. Power-good is low from the first cycle of shutdown.
- R9: Shutdown (state 5) drops the aux enable first and keeps the other three enables high until the aux-below-threshold input is seen high. Then all enables drop and the state code becomes 6.
- R10: In state 6 the block waits indefinitely. A restart request clears the fault code to 0 and returns to state 0, from which power-up proceeds again. A non-zero fault code holds its value until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_ok_i | input | 1 | Sequencer's own supply is good (async) |
| core_min_i | input | 1 | Core rail above its minimum (async) |
| rail_good_i | input | N_RAIL | Per-rail good flags, bit 0 core, 1 low I/O, 2 high I/O, 3 aux (async) |
| cfg_done_i | input | 1 | Target configuration complete (async) |
| shut_req_i | input | 1 | External shutdown request (async) |
| aux_low_i | input | 1 | Aux rail below its low threshold (async) |
| recycle_i | input | 1 | Restart request after shutdown (async) |
| en_core_o | output | 1 | Core regulator enable |
| en_iolo_o | output | 1 | Low-voltage I/O regulator enable |
| en_iohi_o | output | 1 | High-voltage I/O regulator enable |
| en_aux_o | output | 1 | Aux regulator enable |
| pwr_good_o | output | 1 | Rails stable, configuration may start |
| state_o | output | 3 | State code: 0 wait supply, 1 ramp, 2 aux on, 3 configure, 4 run, 5 aux off, 6 off |
| fault_o | output | 2 | Shutdown cause: 0 none, 1 done timeout, 2 rail fault, 3 external request |

## Verification
The hardest situations to reach are a rail-good glitch that lands partway through the settle count, and a deadline expiry that must be told apart from a late configuration-done. The bench places glitches of random length at random points within the settle window. It then checks that power-good stays low until a full clean count has elapsed. The deadline case is reached by polling for the rising edge of power-good and then checking the state just before and just after the computed limit. Each round picks its shutdown cause at random from a fixed seed. The rail fault case also picks which rail drops at random.

// File: rtl/rseq_pkg.sv
package rseq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_SUP = 3'd0,
    ST_RAMP     = 3'd1,
    ST_AUX_ON   = 3'd2,
    ST_CFG      = 3'd3,
    ST_RUN      = 3'd4,
    ST_AUX_OFF  = 3'd5,
    ST_OFF      = 3'd6
  } rseq_state_e;

  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_DONE_TMO = 2'd1,
    FLT_RAIL     = 2'd2,
    FLT_EXT      = 2'd3
  } rseq_fault_e;
endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/rseq_timer.sv
module rseq_timer #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      cnt_q <= '0;
    else if (run_i && cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LAST);

  // R6: counter never runs past the deadline
  p_timer_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);
endmodule

// File: rtl/rseq_settle.sv
module rseq_settle #(
  parameter int N      = 4,
  parameter int SETTLE = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [N-1:0] good_i,
  output logic         stable_o
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  logic [CW-1:0] cnt_q;
  logic          all_good;

  assign all_good = &good_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i || !all_good)
      cnt_q <= '0;
    else if (cnt_q != LAST)
      cnt_q <= cnt_q + 1'b1;
  end

  assign stable_o = all_good && (cnt_q == LAST);

  // R5: a dropped rail always restarts the count
  p_settle_restart_r5: assert property (@(posedge clk) disable iff (rst)
    !all_good |=> cnt_q == '0);
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import rseq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned DONE_MS    = 520,
  parameter int          SETTLE_CYC = 1024,
  parameter int          N_RAIL     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sup_ok_i,
  input  logic              core_min_i,
  input  logic [N_RAIL-1:0] rail_good_i,
  input  logic              cfg_done_i,
  input  logic              shut_req_i,
  input  logic              aux_low_i,
  input  logic              recycle_i,
  output logic              en_core_o,
  output logic              en_iolo_o,
  output logic              en_iohi_o,
  output logic              en_aux_o,
  output logic              pwr_good_o,
  output logic [2:0]        state_o,
  output logic [1:0]        fault_o
);
  localparam int unsigned TMO_CYC = (CLK_HZ / 1000) * DONE_MS;
  localparam int          NSYNC   = N_RAIL + 6;

  logic [NSYNC-1:0] raw_in, syn_in;
  logic              sup_s, core_min_s, done_s, shut_s, aux_low_s, recycle_s;
  logic [N_RAIL-1:0] good_s;

  assign raw_in = {sup_ok_i, core_min_i, cfg_done_i, shut_req_i,
                   aux_low_i, recycle_i, rail_good_i};

  rseq_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw_in), .q_o(syn_in)
  );

  assign good_s     = syn_in[N_RAIL-1:0];
  assign recycle_s  = syn_in[N_RAIL];
  assign aux_low_s  = syn_in[N_RAIL+1];
  assign shut_s     = syn_in[N_RAIL+2];
  assign done_s     = syn_in[N_RAIL+3];
  assign core_min_s = syn_in[N_RAIL+4];
  assign sup_s      = syn_in[N_RAIL+5];

  rseq_state_e state_q, state_d;
  rseq_fault_e fault_q, fault_d;
  logic        tmo, stable;
  logic        en_core_q, en_io_q, en_aux_q, pg_q;

  rseq_timer #(.LIMIT(TMO_CYC)) u_timer (
    .clk(clk), .rst(rst),
    .clr_i(state_d != state_q),
    .run_i(state_q == ST_CFG),
    .expired_o(tmo)
  );

  rseq_settle #(.N(N_RAIL), .SETTLE(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst),
    .clr_i(state_q != ST_AUX_ON),
    .good_i(good_s),
    .stable_o(stable)
  );

  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    case (state_q)
      ST_WAIT_SUP: if (sup_s) state_d = ST_RAMP;
      ST_RAMP:     if (core_min_s) state_d = ST_AUX_ON;
      ST_AUX_ON:   if (stable) state_d = ST_CFG;
      ST_CFG: begin
        if (!(&good_s)) begin
          state_d = ST_AUX_OFF; fault_d = FLT_RAIL;
        end else if (shut_s) begin
          state_d = ST_AUX_OFF; fault_d = FLT_EXT;
        end else if (done_s) begin
          state_d = ST_RUN;
        end else if (tmo) begin
          state_d = ST_AUX_OFF; fault_d = FLT_DONE_TMO;
        end
      end
      ST_RUN: begin
        if (!(&good_s)) begin
          state_d = ST_AUX_OFF; fault_d = FLT_RAIL;
        end else if (shut_s) begin
          state_d = ST_AUX_OFF; fault_d = FLT_EXT;
        end
      end
      ST_AUX_OFF:  if (aux_low_s) state_d = ST_OFF;
      ST_OFF: begin
        if (recycle_s) begin
          state_d = ST_WAIT_SUP; fault_d = FLT_NONE;
        end
      end
      default: begin
        state_d = ST_WAIT_SUP; fault_d = FLT_NONE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_WAIT_SUP;
      fault_q   <= FLT_NONE;
      en_core_q <= 1'b0;
      en_io_q   <= 1'b0;
      en_aux_q  <= 1'b0;
      pg_q      <= 1'b0;
    end else begin
      state_q   <= state_d;
      fault_q   <= fault_d;
      en_core_q <= (state_d inside {ST_RAMP, ST_AUX_ON, ST_CFG, ST_RUN, ST_AUX_OFF});
      en_io_q   <= (state_d inside {ST_RAMP, ST_AUX_ON, ST_CFG, ST_RUN, ST_AUX_OFF});
      en_aux_q  <= (state_d inside {ST_AUX_ON, ST_CFG, ST_RUN});
      pg_q      <= (state_d inside {ST_CFG, ST_RUN});
    end
  end

  assign en_core_o  = en_core_q;
  assign en_iolo_o  = en_io_q;
  assign en_iohi_o  = en_io_q;
  assign en_aux_o   = en_aux_q;
  assign pwr_good_o = pg_q;
  assign state_o    = state_q;
  assign fault_o    = fault_q;

  // R2: rails come up only after own supply was seen good
  p_sup_before_en_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(en_core_q) |-> $past(sup_s));
  // R4: aux follows core minimum, with core already on
  p_aux_after_core_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(en_aux_q) |-> ($past(core_min_s) && en_core_q));
  // R5: power-good implies every enable is on
  p_pg_rails_on_r5: assert property (@(posedge clk) disable iff (rst)
    pg_q |-> (en_core_q && en_io_q && en_aux_q));
  // R8: power-good is low throughout shutdown
  p_pg_low_shutdown_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_AUX_OFF) |-> !pg_q);
  // R9: other rails drop only after aux is off and below threshold
  p_aux_first_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(en_core_q) |-> (!en_aux_q && $past(aux_low_s) && $past(state_q) == ST_AUX_OFF));
  // R10: cause code holds until restart
  p_fault_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_OFF && fault_q != FLT_NONE) |=> fault_q == $past(fault_q));
endmodule

// File: tb/rail_seq_ctrl_test.sv
module rail_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int HZ         = 100_000;
  localparam int MS         = 5;
  localparam int SETTLE     = 8;
  localparam int NR         = 4;
  localparam int TMO        = (HZ / 1000) * MS;

  logic clk = 0, rst = 1;
  logic sup_ok = 0, core_min = 0, cfg_done = 0, shut_req = 0, aux_low = 0, recycle = 0;
  logic [NR-1:0] rail_good = '0;
  logic en_core, en_iolo, en_iohi, en_aux, pg;
  logic [2:0] state;
  logic [1:0] fault;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rail_seq_ctrl #(.CLK_HZ(HZ), .DONE_MS(MS), .SETTLE_CYC(SETTLE), .N_RAIL(NR)) uut (
    .clk(clk), .rst(rst), .sup_ok_i(sup_ok), .core_min_i(core_min),
    .rail_good_i(rail_good), .cfg_done_i(cfg_done), .shut_req_i(shut_req),
    .aux_low_i(aux_low), .recycle_i(recycle),
    .en_core_o(en_core), .en_iolo_o(en_iolo), .en_iohi_o(en_iohi), .en_aux_o(en_aux),
    .pwr_good_o(pg), .state_o(state), .fault_o(fault)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_fault(int cause);
    case (cause)
      0: return 1;
      1: return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int exp_en_bits(int st);
    // {aux, iohi, iolo, core}
    case (st)
      1: return 4'b0111;
      2, 3, 4: return 4'b1111;
      5: return 4'b0111;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic waitn(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int en_bits();
    return {en_aux, en_iohi, en_iolo, en_core};
  endfunction

  task automatic power_up(int glitch_at, int glitch_len);
    int gbit;
    sup_ok = 1;
    waitn(6);
    chk("R3 state", state, 1);
    chk("R3 enables", en_bits(), exp_en_bits(1));
    waitn(20);
    chk("R4 aux held off", en_aux, 0);
    core_min = 1;
    waitn(6);
    chk("R4 state", state, 2);
    chk("R4 enables", en_bits(), exp_en_bits(2));
    rail_good = '1;
    waitn(glitch_at);
    gbit = $urandom_range(0, NR-1);
    rail_good[gbit] = 1'b0;
    waitn(glitch_len);
    rail_good[gbit] = 1'b1;
    waitn(SETTLE - 2);
    chk("R5 pg low after glitch", pg, 0);
    for (int i = 0; i < 12 && !pg; i++) @(negedge clk);
    chk("R5 pg high after settle", pg, 1);
    chk("R5 state", state, 3);
  endtask

  task automatic shut_and_restart(int cause);
    if (cause == 0) begin
      waitn(TMO - 20);
      chk("R6 still waiting before deadline", state, 3);
      chk("R6 pg before deadline", pg, 1);
      waitn(30);
    end else begin
      waitn($urandom_range(5, TMO - 40));
      cfg_done = 1;
      waitn(6);
      chk("R7 running", state, 4);
      chk("R7 pg held", pg, 1);
      waitn($urandom_range(3, 40));
      if (cause == 1) rail_good[$urandom_range(0, NR-1)] = 1'b0;
      else shut_req = 1;
      waitn(5);
    end
    chk("R8 shutdown state", state, 5);
    chk("R8 fault code", fault, exp_fault(cause));
    chk("R8 pg low", pg, 0);
    chk("R9 aux off others on", en_bits(), exp_en_bits(5));
    waitn(20);
    chk("R9 waits for aux low", state, 5);
    aux_low = 1;
    waitn(6);
    chk("R9 off state", state, 6);
    chk("R9 all off", en_bits(), 0);
    waitn(25);
    chk("R10 holds off", state, 6);
    chk("R10 fault sticky", fault, exp_fault(cause));
    rail_good = '0; core_min = 0; cfg_done = 0; shut_req = 0; sup_ok = 0;
    recycle = 1;
    waitn(6);
    recycle = 0; aux_low = 0;
    chk("R10 restart state", state, 0);
    chk("R10 fault cleared", fault, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    waitn(4);
    chk("R1 state", state, 0);
    chk("R1 enables", en_bits(), 0);
    chk("R1 pg", pg, 0);
    chk("R1 fault", fault, 0);
    rst = 0;
    core_min = 1; rail_good = '1;
    waitn(20);
    chk("R2 no enable without supply", en_bits(), 0);
    chk("R2 state", state, 0);
    core_min = 0; rail_good = '0;

    // directed: glitch right at start, timeout path
    power_up(1, 1);
    shut_and_restart(0);
    // directed: glitch near end of count, rail fault
    power_up(SETTLE - 1, 2);
    shut_and_restart(1);

    for (int r = 0; r < 6; r++) begin
      power_up($urandom_range(1, SETTLE - 1), $urandom_range(1, 2));
      shut_and_restart($urandom_range(0, 2));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule